// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block merges three reset sources into one internal reset and one active-low reset-out pin. The sources are a vector of active-low power-on requests, an active-low external reset pin, and a loss-of-lock request from the PLL that only counts when its enable bit is set. Reset is held while any source is active. Once every source has gone quiet, a delay counter runs for a fixed number of cycles and then releases reset-out. A few cycles before that release, the wake/pull configuration pin and the boot configuration pins are captured into a status word. The same status word also records which source caused the reset.

When a power-on reset ends while the crystal clock reference is selected, the sequencer waits for a crystal-stable indication before it starts counting. During that wait it drops a clock-gate enable. If any source comes back during the wait or the countdown, the sequence starts again. Each source has a rank, and within one sequence the recorded cause can only move to a higher-ranked source.

Top module: `rseq_ctrl`

## Requirements
- R1: While any bit of `por_n_vec` is 0, the block holds reset on the following edge: `rst_out_n` 0, `rst_int` 1, `rst_status` all zero. `clk_gate_en` stays 1 while that request is active.
- R2: Reset-out goes low on the first edge that sees `ext_rst_n` at 0. It also goes low on the first edge that sees `pll_unlock` and `lol_rst_en` both at 1. When `lol_rst_en` is 0, `pll_unlock` has no effect.
- R3: When no crystal wait applies, `rst_out_n` rises on the DELAY-th edge after the first edge at which no source is active.
- R4: A crystal wait applies when a power-on sequence releases with `clk_ref_xtal` 1 and `xtal_stable` 0. During the wait, `clk_gate_en` is 0 and the count starts on the first edge that sees `xtal_stable` at 1. External and loss-of-lock sequences never wait and never drop `clk_gate_en`.
- R5: If a source reasserts during the countdown, the block returns to holding reset. After the next release the full DELAY count runs again.
- R6: `wake_cfg_pin` and `boot_cfg_pin` are captured on the edge exactly LEAD edges before `rst_out_n` rises (LEAD = 4). Pin changes after that edge do not reach `rst_status`.
- R7: The `rst_status` layout is: bit 0 power-on, bit 1 external, bit 2 loss-of-lock, bit 3 captured wake pin, bits 5:4 captured boot pins. The cause codes in bits 2:0 are 3'b011 for power-on, 3'b010 for external and 3'b100 for loss-of-lock. `rst_status` changes only at the capture edge or during power-on.
- R8: Source ranks are power-on, then external, then loss-of-lock. Within one sequence, the recorded cause rises to the highest-ranked source seen and never falls back. A sequence that starts from run takes the cause of the source that starts it.
- R9: `pull_up_sel` takes the value of `wake_cfg_pin` on every edge at which a source holds reset. It keeps that value through the countdown and while running.
- R10: `rst_int` is always the complement of `rst_out_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n_vec | input | N_POR | Active-low power-on requests from the supply detectors |
| ext_rst_n | input | 1 | Active-low external reset pin |
| pll_unlock | input | 1 | PLL reports loss of lock |
| lol_rst_en | input | 1 | Enables loss of lock as a reset source |
| clk_ref_xtal | input | 1 | Clock reference select, 1 for crystal, 0 for external clock |
| xtal_stable | input | 1 | Crystal oscillator reported stable |
| wake_cfg_pin | input | 1 | Weak pull direction configuration pin |
| boot_cfg_pin | input | BOOT_W | Boot configuration pins |
| rst_int | output | 1 | Internal reset, active high |
| rst_out_n | output | 1 | Reset-out pin, active low |
| clk_gate_en | output | 1 | Clock-gate enable, 0 while waiting for the crystal |
| pull_up_sel | output | 1 | Applied weak pull direction |
| rst_status | output | BOOT_W+4 | Reset cause and captured configuration |

## Verification
The release path is driven once for each source: power-on with the external reference, power-on with the crystal reference and several crystal delays, external, and gated loss-of-lock. Timing the release and reading the cause code separates the sources, and separates the waiting path from the non-waiting one. Overlapping sources are used to show that the cause only moves upward in rank. Reasserting a source mid-count shows that the counter restarts. The configuration pins are changed one edge before the capture point and one edge after it, which pins the capture to a single edge. Loss of lock with its enable clear shows that the enable gates that source.

// File: rtl/rseq_pkg.sv
package rseq_pkg;

  typedef enum logic [1:0] {
    CAUSE_NONE = 2'd0,
    CAUSE_LOL  = 2'd1,
    CAUSE_EXT  = 2'd2,
    CAUSE_POR  = 2'd3
  } rseq_cause_e;

  typedef enum logic [1:0] {
    ST_HOLD  = 2'd0,
    ST_XWAIT = 2'd1,
    ST_COUNT = 2'd2,
    ST_RUN   = 2'd3
  } rseq_state_e;

  // Higher encoding means higher rank.
  function automatic rseq_cause_e cause_max(rseq_cause_e a, rseq_cause_e b);
    return (a > b) ? a : b;
  endfunction

  // Status cause field {lol, ext, por}.
  function automatic logic [2:0] cause_bits(rseq_cause_e c);
    case (c)
      CAUSE_POR: return 3'b011;
      CAUSE_EXT: return 3'b010;
      CAUSE_LOL: return 3'b100;
      default:   return 3'b000;
    endcase
  endfunction

  // Counter value at which the pins are captured.
  function automatic int sample_mark(int delay, int lead);
    return delay - lead;
  endfunction

endpackage

// File: rtl/rseq_src_merge.sv
module rseq_src_merge
  import rseq_pkg::*;
#(
  parameter int N_POR = 2
) (
  input  logic [N_POR-1:0] por_n_vec,
  input  logic             ext_rst_n,
  input  logic             pll_unlock,
  input  logic             lol_rst_en,
  output logic             por_req,
  output logic             ext_req,
  output logic             lol_req,
  output logic             any_req,
  output rseq_cause_e      top_cause
);

  assign por_req = ~(&por_n_vec);
  assign ext_req = ~ext_rst_n;
  assign lol_req = pll_unlock & lol_rst_en;
  assign any_req = por_req | ext_req | lol_req;

  always_comb begin
    if (por_req)      top_cause = CAUSE_POR;
    else if (ext_req) top_cause = CAUSE_EXT;
    else if (lol_req) top_cause = CAUSE_LOL;
    else              top_cause = CAUSE_NONE;
  end

endmodule

// File: rtl/rseq_delay_cnt.sv
module rseq_delay_cnt
  import rseq_pkg::*;
#(
  parameter int DELAY = 64,
  parameter int LEAD  = 4
) (
  input  logic clk,
  input  logic run,
  output logic sample_now,
  output logic expire
);

  localparam int CW = $clog2(DELAY + 2);
  localparam logic [CW-1:0] LAST = CW'(DELAY);
  localparam logic [CW-1:0] MARK = CW'(sample_mark(DELAY, LEAD));
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [CW-1:0] cnt_q;

  // Count is 1 during the first countdown cycle.
  always_ff @(posedge clk) begin
    if (!run) cnt_q <= ONE;
    else      cnt_q <= cnt_q + ONE;
  end

  assign sample_now = run && (cnt_q == MARK);
  assign expire     = run && (cnt_q == LAST);

endmodule

// File: rtl/rseq_status.sv
module rseq_status
  import rseq_pkg::*;
#(
  parameter int BOOT_W = 2
) (
  input  logic              clk,
  input  logic              por_req,
  input  logic              capture,
  input  rseq_cause_e       cause,
  input  logic              wake_pin,
  input  logic [BOOT_W-1:0] boot_pin,
  output logic [BOOT_W+3:0] status
);

  logic [BOOT_W+3:0] stat_q;

  always_ff @(posedge clk) begin
    if (por_req)      stat_q <= '0;
    else if (capture) stat_q <= {boot_pin, wake_pin, cause_bits(cause)};
  end

  assign status = stat_q;

endmodule

// File: rtl/rseq_ctrl.sv
module rseq_ctrl
  import rseq_pkg::*;
#(
  parameter int N_POR  = 2,
  parameter int BOOT_W = 2,
  parameter int DELAY  = 64,
  parameter int LEAD   = 4
) (
  input  logic              clk,
  input  logic [N_POR-1:0]  por_n_vec,
  input  logic              ext_rst_n,
  input  logic              pll_unlock,
  input  logic              lol_rst_en,
  input  logic              clk_ref_xtal,
  input  logic              xtal_stable,
  input  logic              wake_cfg_pin,
  input  logic [BOOT_W-1:0] boot_cfg_pin,
  output logic              rst_int,
  output logic              rst_out_n,
  output logic              clk_gate_en,
  output logic              pull_up_sel,
  output logic [BOOT_W+3:0] rst_status
);

  logic        por_req, ext_req, lol_req, any_req;
  rseq_cause_e top_cause;
  rseq_state_e state_q, state_d;
  rseq_cause_e cause_q;
  logic        ref_q, pull_q;
  logic        st_count, sample_now, expire, xtal_gate;

  rseq_src_merge #(.N_POR(N_POR)) u_merge (
    .por_n_vec (por_n_vec),
    .ext_rst_n (ext_rst_n),
    .pll_unlock(pll_unlock),
    .lol_rst_en(lol_rst_en),
    .por_req   (por_req),
    .ext_req   (ext_req),
    .lol_req   (lol_req),
    .any_req   (any_req),
    .top_cause (top_cause)
  );

  assign st_count  = (state_q == ST_COUNT);
  assign xtal_gate = (cause_q == CAUSE_POR) && ref_q && !xtal_stable;

  always_comb begin
    state_d = state_q;
    if (any_req) begin
      state_d = ST_HOLD;
    end else begin
      case (state_q)
        ST_HOLD:  state_d = xtal_gate ? ST_XWAIT : ST_COUNT;
        ST_XWAIT: state_d = xtal_stable ? ST_COUNT : ST_XWAIT;
        ST_COUNT: state_d = expire ? ST_RUN : ST_COUNT;
        default:  state_d = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (por_req) begin
      state_q <= ST_HOLD;
      cause_q <= CAUSE_POR;
      ref_q   <= clk_ref_xtal;
      pull_q  <= wake_cfg_pin;
    end else begin
      state_q <= state_d;
      if (any_req) begin
        ref_q   <= clk_ref_xtal;
        pull_q  <= wake_cfg_pin;
        cause_q <= (state_q == ST_RUN) ? top_cause : cause_max(cause_q, top_cause);
      end
    end
  end

  rseq_delay_cnt #(.DELAY(DELAY), .LEAD(LEAD)) u_cnt (
    .clk       (clk),
    .run       (st_count),
    .sample_now(sample_now),
    .expire    (expire)
  );

  rseq_status #(.BOOT_W(BOOT_W)) u_stat (
    .clk     (clk),
    .por_req (por_req),
    .capture (sample_now),
    .cause   (cause_q),
    .wake_pin(wake_cfg_pin),
    .boot_pin(boot_cfg_pin),
    .status  (rst_status)
  );

  assign rst_out_n   = (state_q == ST_RUN);
  assign rst_int     = (state_q != ST_RUN);
  assign clk_gate_en = (state_q != ST_XWAIT);
  assign pull_up_sel = pull_q;

endmodule

// File: rtl/rseq_ctrl_chk.sv
module rseq_ctrl_chk #(
  parameter int BOOT_W = 2,
  parameter int DELAY  = 64,
  parameter int LEAD   = 4
) (
  input logic              clk,
  input logic              por_req,
  input logic              sample_now,
  input logic              ext_rst_n,
  input logic              pll_unlock,
  input logic              lol_rst_en,
  input logic              xtal_stable,
  input logic              wake_cfg_pin,
  input logic              rst_int,
  input logic              rst_out_n,
  input logic              clk_gate_en,
  input logic              pull_up_sel,
  input logic [BOOT_W+3:0] rst_status
);

  localparam int QW = $clog2(DELAY + 3);
  localparam logic [QW-1:0] QMAX = QW'(DELAY + 1);
  localparam int SW = $clog2(LEAD + 3);
  localparam logic [SW-1:0] SMAX = SW'(LEAD + 1);

  logic armed = 1'b0;
  logic [QW-1:0] quiet_q;
  logic [SW-1:0] since_q;
  logic side_req;

  assign side_req = !ext_rst_n || (pll_unlock && lol_rst_en);

  always_ff @(posedge clk) begin
    armed <= armed | por_req;
    if (por_req || side_req)  quiet_q <= '0;
    else if (quiet_q != QMAX) quiet_q <= quiet_q + QW'(1);
    if (por_req)              since_q <= SMAX;
    else if (sample_now)      since_q <= '0;
    else if (since_q != SMAX) since_q <= since_q + SW'(1);
  end

  assert_por_hold_R1: assert property (@(posedge clk) disable iff (!armed)
    por_req |=> (!rst_out_n && rst_status == '0 && clk_gate_en));

  assert_src_hold_R2: assert property (@(posedge clk) disable iff (por_req)
    side_req |=> !rst_out_n);

  assert_release_delay_R3: assert property (@(posedge clk) disable iff (por_req)
    $rose(rst_out_n) |-> (quiet_q >= QW'(DELAY)));

  assert_gate_release_R4: assert property (@(posedge clk) disable iff (por_req)
    (!clk_gate_en && xtal_stable && !side_req) |=> clk_gate_en);

  assert_gate_in_reset_R4: assert property (@(posedge clk) disable iff (por_req)
    !clk_gate_en |-> !rst_out_n);

  assert_sample_lead_R6: assert property (@(posedge clk) disable iff (por_req)
    $rose(rst_out_n) |-> (since_q == SW'(LEAD)));

  assert_status_stable_R7: assert property (@(posedge clk) disable iff (por_req)
    !sample_now |=> $stable(rst_status));

  assert_status_code_R7: assert property (@(posedge clk) disable iff (por_req)
    rst_status[0] |-> (rst_status[1] && !rst_status[2]));

  assert_pull_follow_R9: assert property (@(posedge clk) disable iff (por_req)
    !ext_rst_n |=> (pull_up_sel == $past(wake_cfg_pin)));

  assert_out_pair_R10: assert property (@(posedge clk) disable iff (!armed)
    rst_int != rst_out_n);

endmodule

bind rseq_ctrl rseq_ctrl_chk #(.BOOT_W(BOOT_W), .DELAY(DELAY), .LEAD(LEAD)) u_chk (
  .clk         (clk),
  .por_req     (por_req),
  .sample_now  (sample_now),
  .ext_rst_n   (ext_rst_n),
  .pll_unlock  (pll_unlock),
  .lol_rst_en  (lol_rst_en),
  .xtal_stable (xtal_stable),
  .wake_cfg_pin(wake_cfg_pin),
  .rst_int     (rst_int),
  .rst_out_n   (rst_out_n),
  .clk_gate_en (clk_gate_en),
  .pull_up_sel (pull_up_sel),
  .rst_status  (rst_status)
);

// File: tb/rseq_ctrl_bench.sv
module rseq_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int N_POR  = 2;
  localparam int BOOT_W = 2;
  localparam int DELAY  = 64;
  localparam int LEAD   = 4;
  localparam int NV     = 6;

  // {src[1:0] (0 power-on, 1 external, 2 loss-of-lock), ref, wake, boot[1:0], 2'b0, xtal_k[7:0]}
  localparam logic [15:0] VECS [NV] = '{
    {2'd0, 1'b0, 1'b1, 2'b10, 2'b00, 8'd0},
    {2'd0, 1'b1, 1'b0, 2'b01, 2'b00, 8'd5},
    {2'd1, 1'b1, 1'b1, 2'b11, 2'b00, 8'd0},
    {2'd2, 1'b0, 1'b0, 2'b00, 2'b00, 8'd0},
    {2'd1, 1'b0, 1'b0, 2'b01, 2'b00, 8'd0},
    {2'd0, 1'b1, 1'b1, 2'b11, 2'b00, 8'd1}
  };

  logic              clk = 1'b0;
  logic [N_POR-1:0]  por_n_vec = '0;
  logic              ext_rst_n = 1'b1;
  logic              pll_unlock = 1'b0;
  logic              lol_rst_en = 1'b0;
  logic              clk_ref_xtal = 1'b0;
  logic              xtal_stable = 1'b1;
  logic              wake_cfg_pin = 1'b0;
  logic [BOOT_W-1:0] boot_cfg_pin = '0;
  logic              rst_int, rst_out_n, clk_gate_en, pull_up_sel;
  logic [BOOT_W+3:0] rst_status;

  int total = 0;
  int fails = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rseq_ctrl #(.N_POR(N_POR), .BOOT_W(BOOT_W), .DELAY(DELAY), .LEAD(LEAD)) u_rseq_ctrl (
    .clk(clk), .por_n_vec(por_n_vec), .ext_rst_n(ext_rst_n), .pll_unlock(pll_unlock),
    .lol_rst_en(lol_rst_en), .clk_ref_xtal(clk_ref_xtal), .xtal_stable(xtal_stable),
    .wake_cfg_pin(wake_cfg_pin), .boot_cfg_pin(boot_cfg_pin), .rst_int(rst_int),
    .rst_out_n(rst_out_n), .clk_gate_en(clk_gate_en), .pull_up_sel(pull_up_sel),
    .rst_status(rst_status)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] exp_stat(input int src, input logic wk, input logic [1:0] bt);
    logic [2:0] c;
    c = (src == 2) ? 3'b100 : ((src == 1) ? 3'b010 : 3'b011);
    return {bt, wk, c};
  endfunction

  function automatic int exp_edges(input int src, input logic rf, input int k);
    int extra;
    extra = (src == 0 && rf) ? k : 0;
    return DELAY + 1 + extra;
  endfunction

  task automatic raise_src(input int src);
    if (src == 0) por_n_vec = 2'b10;
    else if (src == 1) ext_rst_n = 1'b0;
    else begin pll_unlock = 1'b1; lol_rst_en = 1'b1; end
  endtask

  task automatic drop_all();
    por_n_vec = '1; ext_rst_n = 1'b1; pll_unlock = 1'b0;
  endtask

  // Counts negedges until reset-out is seen high; raises xtal at count k.
  task automatic time_release(input int k, output int n, output logic gate1);
    n = 0; gate1 = 1'b1;
    do begin
      @(negedge clk);
      n++;
      if (n == 1) gate1 = clk_gate_en;
      if (k > 0 && n == k) xtal_stable = 1'b1;
    end while (!rst_out_n && n < 5000);
  endtask

  task automatic run_case(input int src, input logic rf, input logic wk,
                          input logic [1:0] bt, input int k, input int idx);
    int n; logic g1;
    @(negedge clk);
    xtal_stable = (src == 0) ? (k == 0) : 1'b0;
    clk_ref_xtal = rf; wake_cfg_pin = wk; boot_cfg_pin = bt;
    raise_src(src);
    repeat (3) @(negedge clk);
    chk($sformatf("R2 vec%0d reset-out low", idx), 32'(rst_out_n), 32'd0);
    chk($sformatf("R10 vec%0d internal reset", idx), 32'(rst_int), 32'd1);
    chk($sformatf("R9 vec%0d pull follows pin", idx), 32'(pull_up_sel), 32'(wk));
    if (src == 0) chk($sformatf("R1 vec%0d status cleared", idx), 32'(rst_status), 32'd0);
    drop_all();
    time_release(k, n, g1);
    chk($sformatf("R3/R4 vec%0d release edges", idx), 32'(n), 32'(exp_edges(src, rf, k)));
    chk($sformatf("R4 vec%0d gate after release", idx), 32'(g1),
        32'((src == 0 && rf && k > 0) ? 0 : 1));
    chk($sformatf("R7 vec%0d status", idx), 32'(rst_status), 32'(exp_stat(src, wk, bt)));
    xtal_stable = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int n; logic g1;
    // R1 reset state while a power-on request is held
    repeat (4) @(negedge clk);
    chk("R1 reset-out during power-on", 32'(rst_out_n), 32'd0);
    chk("R10 internal reset during power-on", 32'(rst_int), 32'd1);
    chk("R1 status during power-on", 32'(rst_status), 32'd0);
    chk("R1 gate during power-on", 32'(clk_gate_en), 32'd1);
    drop_all();
    time_release(0, n, g1);
    chk("R3 first release", 32'(n), 32'(DELAY + 1));

    for (int i = 0; i < NV; i++) begin
      run_case(int'(VECS[i][15:14]), VECS[i][13], VECS[i][12], VECS[i][11:10],
               int'(VECS[i][7:0]), i);
    end

    // R2: loss of lock ignored with enable clear
    @(negedge clk);
    lol_rst_en = 1'b0; pll_unlock = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R2 lol without enable", 32'(rst_out_n), 32'd1);
    end
    chk("R2 status untouched", 32'(rst_status), 32'(exp_stat(0, 1'b1, 2'b11)));
    pll_unlock = 1'b0;

    // R5: reassert mid-count restarts the full delay
    @(negedge clk);
    ext_rst_n = 1'b0; wake_cfg_pin = 1'b0; boot_cfg_pin = 2'b00;
    repeat (2) @(negedge clk);
    ext_rst_n = 1'b1;
    repeat (20) @(negedge clk);
    chk("R5 still counting", 32'(rst_out_n), 32'd0);
    ext_rst_n = 1'b0;
    repeat (2) @(negedge clk);
    ext_rst_n = 1'b1;
    time_release(0, n, g1);
    chk("R5 full delay after restart", 32'(n), 32'(DELAY + 1));

    // R6: pins changed just before the capture edge are taken
    @(negedge clk);
    ext_rst_n = 1'b0; wake_cfg_pin = 1'b0; boot_cfg_pin = 2'b00;
    repeat (2) @(negedge clk);
    ext_rst_n = 1'b1;
    n = 0;
    do begin
      @(negedge clk); n++;
      if (n == DELAY - LEAD) begin wake_cfg_pin = 1'b1; boot_cfg_pin = 2'b10; end
    end while (!rst_out_n && n < 5000);
    chk("R6 capture on marked edge", 32'(rst_status), 32'(exp_stat(1, 1'b1, 2'b10)));
    chk("R9 pull keeps hold value", 32'(pull_up_sel), 32'd0);

    // R6: pins changed one edge after the capture edge are not taken
    @(negedge clk);
    ext_rst_n = 1'b0; wake_cfg_pin = 1'b0; boot_cfg_pin = 2'b01;
    repeat (2) @(negedge clk);
    ext_rst_n = 1'b1;
    n = 0;
    do begin
      @(negedge clk); n++;
      if (n == DELAY - LEAD + 1) begin wake_cfg_pin = 1'b1; boot_cfg_pin = 2'b10; end
    end while (!rst_out_n && n < 5000);
    chk("R6 late pin change ignored", 32'(rst_status), 32'(exp_stat(1, 1'b0, 2'b01)));

    // R8: loss of lock then external -> external recorded
    @(negedge clk);
    wake_cfg_pin = 1'b0; boot_cfg_pin = 2'b00;
    lol_rst_en = 1'b1; pll_unlock = 1'b1;
    repeat (2) @(negedge clk);
    ext_rst_n = 1'b0;
    repeat (2) @(negedge clk);
    drop_all();
    time_release(0, n, g1);
    chk("R8 upgrade to external", 32'(rst_status), 32'(exp_stat(1, 1'b0, 2'b00)));

    // R8: external then loss of lock still held -> no downgrade
    @(negedge clk);
    ext_rst_n = 1'b0; pll_unlock = 1'b1;
    repeat (2) @(negedge clk);
    ext_rst_n = 1'b1;
    repeat (3) @(negedge clk);
    pll_unlock = 1'b0;
    time_release(0, n, g1);
    chk("R8 no downgrade", 32'(rst_status), 32'(exp_stat(1, 1'b0, 2'b00)));
    chk("R3 release after overlap", 32'(n), 32'(DELAY + 1));

    // R8: fresh sequence from run takes its own cause
    run_case(2, 1'b0, 1'b1, 2'b01, 0, 90);

    // R8: power-on during external hold -> power-on code
    @(negedge clk);
    clk_ref_xtal = 1'b0; ext_rst_n = 1'b0;
    repeat (2) @(negedge clk);
    por_n_vec = 2'b01;
    repeat (2) @(negedge clk);
    drop_all();
    time_release(0, n, g1);
    chk("R8 power-on outranks external", 32'(rst_status[2:0]), 32'd3);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule